// File: doc/BRIEF.md
# Serial Memory Bus Target Engine

This block is the bus-facing front end of a 256-byte serial memory that sits on a two-wire I2C bus as a target. It watches the bus clock and data lines, which arrive already synchronised to the system clock. It finds START and STOP conditions and shifts bytes in and out. It answers by asserting an open-drain pull-down enable on the data line, both for acknowledge bits and for read data.

The first byte of each transfer is a control byte. It carries a four-bit device code, three select bits that must equal the strap inputs, and a direction bit. A write transfer loads the next byte into the internal byte pointer. Every byte after that is handed to the memory side as a write strobe. The memory side starts its internal write cycle when the engine pulses a commit output.

A read transfer fetches bytes from the memory side through a read strobe with one cycle of latency. It sends them most significant bit first and keeps going for as long as the master acknowledges. While the write controller reports busy, the engine refuses every control byte, so the master can poll for the end of the write cycle. The bus output only changes a fixed number of system clocks after the bus clock falls.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A control byte of the form {4'b1010, strap_i[2:0], rw} is acknowledged: the engine asserts sda_oe_o throughout the high phase of the ninth bus clock. rw=0 selects write and rw=1 selects read.
- R2: A control byte whose upper four bits differ from 1010, or whose bits [3:1] differ from strap_i, is not acknowledged. The engine then neither acknowledges nor strobes the memory until the next START.
- R3: While busy_i is high, no control byte is acknowledged, even a matching one. Once busy_i is low, the same control byte is acknowledged.
- R4: In a write transfer, the byte after the control byte is acknowledged and becomes the byte pointer. A STOP or repeated START right after it keeps the pointer and produces no wr_cycle_o pulse.
- R5: Each further byte of a write transfer is acknowledged and produces one mem_wr_o pulse while SCL is low, carrying mem_addr_o equal to the pointer and mem_wdata_o equal to the byte. After that byte, the low four pointer bits step by one and wrap within the 16-byte page, while the upper bits hold.
- R6: A STOP or START that ends a write transfer with at least one data byte produces a single-cycle wr_cycle_o pulse.
- R7: A read transfer sends the byte at the pointer MSB first (sda_oe_o high means a 0 bit), then advances the pointer by one.
- R8: After a read byte, a master ACK makes the engine send the byte at the next address. The 8-bit pointer wraps from 0xFF to 0x00.
- R9: After a read byte, a master NACK makes the engine release the data line until the next condition. A later current-address read resumes at the byte after the last one sent.
- R10: sda_oe_o is low after reset and changes only while SCL is low, exactly HOLD_CLKS+1 system clocks after SCL is first sampled low.
- R11: A START or STOP in the middle of a byte abandons the transfer. The partial byte produces no mem_wr_o, and a START begins a new control byte at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| strap_i | input | 3 | Device select straps compared with control byte bits [3:1] |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Pull the data line low when high |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_wr_o | output | 1 | One-cycle byte write strobe |
| mem_addr_o | output | 8 | Byte address for either strobe |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| wr_cycle_o | output | 1 | One-cycle pulse to start the internal write cycle |

## Verification
The engine is driven with a byte write, a write that runs past the end of a page, and an address-only write followed by current-address reads. These tell apart a pointer that only loads from one that advances and wraps inside the page. A random read with a repeated START and a sequential read across 0xFF show that the read pointer advances over the whole byte range, unlike the write pointer. Control bytes with the wrong code, wrong straps or busy asserted separate the refusal cases from the acknowledged ones. Transfers cut short by a STOP or START in mid-byte show that partial bytes are dropped.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int PTR_W    = 8;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(BYTE_W + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WADDR,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic ctrl_hit(input logic [BYTE_W-1:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_CODE) && (b[3:1] == strap);
    endfunction

    // advance only the bits under the page mask, keep the rest
    function automatic ptr_t page_step(input ptr_t p, input ptr_t mask);
        return (p & ~mask) | ((p + ptr_t'(1)) & mask);
    endfunction

endpackage

// File: rtl/i2ct_busmon.sv
module i2ct_busmon
    import i2ct_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev_o.rise  = scl_i & ~scl_q;
        ev_o.fall  = ~scl_i & scl_q;
    end
endmodule

// File: rtl/i2ct_sda_hold.sv
module i2ct_sda_hold #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic oe_o
);
    generate
        if (HOLD <= 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) oe_o <= 1'b0;
                else     oe_o <= req_i;
            end
        end else begin : g_pipe
            logic [HOLD-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[HOLD-2:0], req_i};
            end
            assign oe_o = pipe[HOLD-1];
        end
    endgenerate
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import i2ct_pkg::*;
#(
    parameter int HOLD_CLKS = 3,
    parameter int PAGE_BITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       strap_i,
    input  logic             busy_i,
    output logic             sda_oe_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [PTR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic             wr_cycle_o
);
    localparam ptr_t PAGE_MASK = ptr_t'((1 << PAGE_BITS) - 1);

    bus_ev_t           ev;
    phase_t            phase;
    phase_t            next_ph;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    ptr_t              ptr;
    logic              wrote;
    logic              rd_pend;
    logic              drive_req;

    i2ct_busmon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2ct_sda_hold #(.HOLD(HOLD_CLKS)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .req_i (drive_req),
        .oe_o  (sda_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            next_ph     <= PH_IDLE;
            bitcnt      <= '0;
            rx          <= '0;
            tx          <= '0;
            ptr         <= '0;
            wrote       <= 1'b0;
            rd_pend     <= 1'b0;
            drive_req   <= 1'b0;
            mem_rd_o    <= 1'b0;
            mem_wr_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            wr_cycle_o  <= 1'b0;
        end else begin
            mem_rd_o   <= 1'b0;
            mem_wr_o   <= 1'b0;
            wr_cycle_o <= 1'b0;
            rd_pend    <= mem_rd_o;
            if (rd_pend) tx <= mem_rdata_i;

            if (ev.start || ev.stop) begin
                // R6 / R11: any condition closes the current transfer
                if (wrote) wr_cycle_o <= 1'b1;
                wrote     <= 1'b0;
                drive_req <= 1'b0;
                bitcnt    <= '0;
                rx        <= '0;
                phase     <= ev.start ? PH_CTRL : PH_IDLE;
            end else if (phase != PH_IDLE && phase != PH_IGNORE) begin
                if (ev.rise) begin
                    if (bitcnt < ACK_SLOT) begin
                        rx     <= {rx[BYTE_W-2:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (bitcnt == ACK_SLOT) begin
                        bitcnt <= END_SLOT;
                        if (phase == PH_RDATA) begin
                            if (!sda_i) begin
                                // master ACK: fetch the following byte
                                next_ph    <= PH_RDATA;
                                mem_rd_o   <= 1'b1;
                                mem_addr_o <= ptr;
                                ptr        <= ptr + 1'b1;
                            end else begin
                                next_ph <= PH_IGNORE;
                            end
                        end
                    end
                end else if (ev.fall) begin
                    if (bitcnt == END_SLOT) begin
                        bitcnt    <= '0;
                        phase     <= next_ph;
                        drive_req <= (next_ph == PH_RDATA) ? ~tx[BYTE_W-1] : 1'b0;
                    end else if (bitcnt == ACK_SLOT) begin
                        case (phase)
                            PH_CTRL: begin
                                if (ctrl_hit(rx, strap_i) && !busy_i) begin
                                    drive_req <= 1'b1;
                                    if (rx[0]) begin
                                        next_ph    <= PH_RDATA;
                                        mem_rd_o   <= 1'b1;
                                        mem_addr_o <= ptr;
                                        ptr        <= ptr + 1'b1;
                                    end else begin
                                        next_ph <= PH_WADDR;
                                    end
                                end else begin
                                    drive_req <= 1'b0;
                                    next_ph   <= PH_IGNORE;
                                end
                            end
                            PH_WADDR: begin
                                drive_req <= 1'b1;
                                ptr       <= rx[PTR_W-1:0];
                                next_ph   <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                drive_req   <= 1'b1;
                                mem_wr_o    <= 1'b1;
                                mem_addr_o  <= ptr;
                                mem_wdata_o <= rx;
                                ptr         <= page_step(ptr, PAGE_MASK);
                                wrote       <= 1'b1;
                                next_ph     <= PH_WDATA;
                            end
                            default: begin
                                drive_req <= 1'b0;
                            end
                        endcase
                    end else if (phase == PH_RDATA && bitcnt != '0) begin
                        drive_req <= ~tx[3'(4'd7 - bitcnt)];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe_o,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic wr_cycle_o
);
    // R10
    oe_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    // R5
    wr_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> !scl_i);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_o && mem_rd_o));

    // R6
    cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cycle_o |=> !wr_cycle_o);

    // R6
    cycle_on_cond_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cycle_o |-> scl_i);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !mem_rd_o);
endmodule

bind eeprom_i2c_target i2ct_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .wr_cycle_o (wr_cycle_o)
);

// File: tb/sim_eeprom_i2c_target.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_line;
    logic sda_oe, mem_rd, mem_wr, wr_cycle;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int cyc_count = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target #(.HOLD_CLKS(HOLD), .PAGE_BITS(4)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(STRAP), .busy_i(busy), .sda_oe_o(sda_oe),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .wr_cycle_o(wr_cycle)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_wr) begin
                mem[mem_addr] <= mem_wdata;
                wr_count <= wr_count + 1;
            end
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (wr_cycle) cyc_count <= cyc_count + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R10 monitor: every change of the pull-down enable lands HOLD+1 clocks after SCL falls
    int since_fall = 1000;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst) begin
            since_fall = 1000;
            prev_scl = scl_m;
            prev_oe = sda_oe;
        end else begin
            if (prev_scl && !scl_m) since_fall = 1;
            else if (since_fall < 1000) since_fall++;
            if (sda_oe !== prev_oe) begin
                checks++;
                if (scl_m || since_fall != HOLD + 1) begin
                    errors++;
                    $display("FAIL R10: actual scl=%0d delay=%0d expected scl=0 delay=%0d",
                             scl_m, since_fall, HOLD + 1);
                end
            end
            prev_scl = scl_m;
            prev_oe = sda_oe;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic tx_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(2);
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        tx_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q/2);
        ack = ~sda_line; wq(Q/2);
        scl_m = 1'b0; wq(2);
    endtask

    task automatic rx_byte(input logic master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q/2);
            b[i] = sda_line; wq(Q/2);
            scl_m = 1'b0; wq(2);
        end
        sda_m = master_ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(2);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic ack;
        bus_start(); tx_byte(CW, ack); tx_byte(a, ack); bus_stop();
    endtask

    task automatic t_reset();
        check("R10 reset oe", sda_oe, 0);
        check("R5 reset wr", mem_wr, 0);
        check("R6 reset cycle", wr_cycle, 0);
    endtask

    task automatic t_byte_write();
        logic ack; logic [7:0] d; int c0;
        c0 = cyc_count;
        bus_start();
        tx_byte(CW, ack);   check("R1 ctrl write ack", ack, 1);
        tx_byte(8'h20, ack); check("R4 addr ack", ack, 1);
        tx_byte(8'h3C, ack); check("R5 data ack", ack, 1);
        bus_stop(); wq(2);
        check("R5 mem written", mem[8'h20], 8'h3C);
        check("R6 one cycle pulse", cyc_count - c0, 1);
        bus_start(); tx_byte(CW, ack); tx_byte(8'h20, ack);
        bus_start(); tx_byte(CR, ack); check("R1 ctrl read ack", ack, 1);
        rx_byte(1'b0, d); bus_stop();
        check("R7 random read back", d, 8'h3C);
    endtask

    task automatic t_addr_only();
        logic ack; logic [7:0] d; int c0;
        c0 = cyc_count;
        set_ptr(8'h40); wq(2);
        check("R4 no cycle after addr only", cyc_count - c0, 0);
        bus_start(); tx_byte(CR, ack); rx_byte(1'b0, d); bus_stop();
        check("R7 current read", d, init_val(8'h40));
        bus_start(); tx_byte(CR, ack); rx_byte(1'b0, d); bus_stop();
        check("R9 resumes after nack", d, init_val(8'h41));
    endtask

    task automatic t_seq_wrap();
        logic ack; logic [7:0] d;
        set_ptr(8'hFE);
        bus_start(); tx_byte(CR, ack);
        rx_byte(1'b1, d); check("R8 seq byte FE", d, init_val(8'hFE));
        rx_byte(1'b1, d); check("R8 seq byte FF", d, init_val(8'hFF));
        rx_byte(1'b0, d); check("R8 seq wrap 00", d, init_val(8'h00));
        bus_stop();
        bus_start(); tx_byte(CR, ack); rx_byte(1'b0, d); bus_stop();
        check("R9 next after wrap", d, init_val(8'h01));
    endtask

    task automatic t_page_wrap();
        logic ack; int c0;
        c0 = cyc_count;
        bus_start(); tx_byte(CW, ack); tx_byte(8'h1E, ack);
        tx_byte(8'hA1, ack); tx_byte(8'hA2, ack); tx_byte(8'hA3, ack);
        check("R5 third data ack", ack, 1);
        bus_stop(); wq(2);
        check("R5 page 1E", mem[8'h1E], 8'hA1);
        check("R5 page 1F", mem[8'h1F], 8'hA2);
        check("R5 page wrap 10", mem[8'h10], 8'hA3);
        check("R5 no spill 20", mem[8'h20], 8'h3C);
        check("R6 single commit", cyc_count - c0, 1);
    endtask

    task automatic t_mismatch();
        logic ack; int w0;
        w0 = wr_count;
        bus_start(); tx_byte({4'b1010, 3'b100, 1'b0}, ack);
        check("R2 strap mismatch nack", ack, 0);
        tx_byte(8'h55, ack); check("R2 ignored byte nack", ack, 0);
        tx_byte(8'h77, ack); check("R2 ignored data nack", ack, 0);
        bus_stop();
        bus_start(); tx_byte({4'b1011, STRAP, 1'b0}, ack);
        check("R2 code mismatch nack", ack, 0);
        tx_byte(8'h66, ack); bus_stop(); wq(2);
        check("R2 no write strobe", wr_count - w0, 0);
    endtask

    task automatic t_busy();
        logic ack;
        busy = 1'b1;
        bus_start(); tx_byte(CW, ack); check("R3 busy write nack", ack, 0);
        bus_start(); tx_byte(CR, ack); check("R3 busy read nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start(); tx_byte(CW, ack); check("R3 ack after busy", ack, 1);
        bus_stop();
    endtask

    task automatic t_abort();
        logic ack; logic [7:0] d; int w0, c0;
        w0 = wr_count; c0 = cyc_count;
        bus_start(); tx_byte(CW, ack); tx_byte(8'h50, ack);
        tx_bits(8'hF0, 4); bus_stop(); wq(2);
        check("R11 partial byte no write", wr_count - w0, 0);
        check("R11 no commit", cyc_count - c0, 0);
        bus_start(); tx_bits(8'h00, 3);
        bus_start(); tx_byte(CR, ack); check("R11 restart ctrl ack", ack, 1);
        rx_byte(1'b0, d); bus_stop();
        check("R11 pointer kept", d, init_val(8'h50));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst = 1'b0;
        wq(3);
        t_reset();
        t_byte_write();
        t_addr_only();
        t_seq_wrap();
        t_page_wrap();
        t_mismatch();
        t_busy();
        t_abort();
        wq(20);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule